// File: doc/BRIEF.md
# Receive Packet Burst Controller

This block moves one software-defined packet of 32-bit words from a bus-master read interface into an on-chip receive FIFO. Software sets a start address, a maximum burst length, an increment-disable flag and a 16-bit padding mode. It then writes the packet length in bytes. The controller breaks the packet into read requests, collects the returned beats and pushes one FIFO entry per beat. A downstream engine drains the FIFO through a first-word-fall-through pop port.

A full burst is requested only when the FIFO has room for every beat of it. Once fewer words remain than the burst length, the controller switches to single-beat reads. After the last word has been stored, the controller waits for a new length write. That write continues from the address after the previous packet, unless software has loaded a new start address first.

Top module: `rx_burst_ctrl`

## Requirements
- R1: The FIFO holds 32 entries of 36 bits each and is first-word-fall-through: `pop_data_o` shows the oldest entry while `fifo_count_o` is nonzero. In word mode an entry is `{4'hF, data[31:0]}`. After reset the count is 0.
- R2: The effective burst length is `max_beats_i`, with 0 treated as 1 and any value above 8 treated as 8. A full burst request carries that length on `rd_beats_o`.
- R3: The packet length in words is `pkt_bytes_i[15:2]`, so the two low bits are ignored. A length of zero words issues no request.
- R4: A request is raised only if the free FIFO entries (32 minus the count) are at least the request's beat count. Otherwise the controller waits with `rd_req_o` low.
- R5: While the remaining words are at least the effective burst length, full bursts are requested. After that, each remaining word is requested as a single-beat read.
- R6: The first request uses the start address with bits [1:0] cleared. Each later request adds beats×4 (beats×2 in 16-bit mode) to the previous request's address. When `no_incr_i` is high, every request of the packet uses the same address.
- R7: A new length write without a new start address continues at the address that would have followed the previous packet's last request. A start-address write made while no request is pending replaces it.
- R8: In 16-bit mode (`half_mode_i` high) each entry is `{4'h3, 16'h0000, data[15:0]}`.
- R9: `done_o` goes high on the clock edge that pushes the packet's last word. It stays high until the next length write clears it. A zero-word packet leaves it low.
- R10: `overflow_o` is a sticky flag that is set when a push arrives while the FIFO is full. In normal operation the room check keeps it at 0.
- R11: `rd_req_o` stays high, with stable `rd_addr_o` and `rd_beats_o`, until `rd_ack_i`. After the acknowledge it drops on the next cycle, and only one request is outstanding at a time. Beats return on `rd_valid_i` with `rd_data_i`, and gaps between beats are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_addr_i | input | 32 | Packet start byte address |
| start_we_i | input | 1 | Load strobe for start address |
| pkt_bytes_i | input | 16 | Packet length in bytes |
| pkt_we_i | input | 1 | Length write strobe; starts a packet |
| max_beats_i | input | 4 | Maximum burst length |
| no_incr_i | input | 1 | Hold the address fixed for the whole packet |
| half_mode_i | input | 1 | 16-bit bus mode with zero padding |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Request byte address |
| rd_beats_o | output | 4 | Request beat count |
| rd_ack_i | input | 1 | Request accepted |
| rd_valid_i | input | 1 | Returned beat valid |
| rd_data_i | input | 32 | Returned beat data |
| pop_i | input | 1 | FIFO pop |
| pop_data_o | output | 36 | Oldest FIFO entry |
| fifo_count_o | output | 6 | FIFO occupancy |
| overflow_o | output | 1 | Sticky overflow flag |
| done_o | output | 1 | Packet complete |

## Verification
The bench keeps its own request plan and its own FIFO occupancy. From these it checks each request's address, length and free room, and it compares count and done on every cycle. The corner cases are:
- A packet whose length is not a multiple of the burst length. A design that splits the tail wrongly would issue a short multi-beat burst instead of single beats.
- A FIFO held full with the pop port idle. A design that skips the room check would request into a full FIFO and set the overflow flag.
- Byte counts with stray low bits, burst lengths of 0 and 15, 16-bit mode and increment-disable. Errors here show up as wrong word counts, wrong clamping, wrong address steps or unpadded entries.
- A follow-on packet without a new start address. A design that forgets where the previous packet stopped would restart at the old base.

// File: rtl/rx_burst_pkg.sv
`timescale 1ns/1ps
package rx_burst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA} rx_state_e;
  localparam logic [3:0] MASK_WORD = 4'hF;
  localparam logic [3:0] MASK_HALF = 4'h3;
endpackage

// File: rtl/rx_word_fifo.sv
`timescale 1ns/1ps
module rx_word_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 36,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             full, push_ok, pop_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] wrap_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= wrap_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= wrap_inc(rd_ptr_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assign data_o     = mem_q[rd_ptr_q];
  assign count_o    = cnt_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/rx_burst_fsm.sv
`timescale 1ns/1ps
module rx_burst_fsm
  import rx_burst_pkg::*;
#(
  parameter int MAX_BURST = 8,
  parameter int WORD_W    = 14,
  parameter int CNT_W     = 6,
  localparam int BEAT_W   = $clog2(MAX_BURST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_we_i,
  input  logic [WORD_W-1:0] pkt_words_i,
  input  logic [BEAT_W-1:0] max_beats_i,
  input  logic [CNT_W-1:0]  free_i,
  input  logic              rd_ack_i,
  input  logic              rd_valid_i,
  output logic              rd_req_o,
  output logic [BEAT_W-1:0] burst_len_o,
  output logic              fire_o,
  output logic              push_o,
  output logic              done_o
);
  rx_state_e         state_q;
  logic [WORD_W-1:0] words_left_q;
  logic [BEAT_W-1:0] len_q, beats_left_q, eff_max, next_len;
  logic              done_q, can_issue;

  always_comb begin
    if (max_beats_i == '0)                          eff_max = BEAT_W'(1);
    else if (max_beats_i > BEAT_W'(MAX_BURST))      eff_max = BEAT_W'(MAX_BURST);
    else                                            eff_max = max_beats_i;
  end

  // tail shorter than a full burst goes out as single beats
  assign next_len  = (words_left_q >= WORD_W'(eff_max)) ? eff_max : BEAT_W'(1);
  assign can_issue = (state_q == ST_IDLE) && (words_left_q != '0) &&
                     (free_i >= CNT_W'(next_len));
  assign rd_req_o  = (state_q == ST_REQ);
  assign fire_o    = rd_req_o && rd_ack_i;
  assign push_o    = (state_q == ST_DATA) && rd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      words_left_q <= '0;
      len_q        <= BEAT_W'(1);
      beats_left_q <= '0;
      done_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (can_issue) begin
          len_q   <= next_len;
          state_q <= ST_REQ;
        end
        ST_REQ: if (rd_ack_i) begin
          beats_left_q <= len_q;
          state_q      <= ST_DATA;
        end
        ST_DATA: if (rd_valid_i) begin
          beats_left_q <= beats_left_q - 1'b1;
          words_left_q <= words_left_q - 1'b1;
          if (words_left_q == WORD_W'(1)) done_q <= 1'b1;
          if (beats_left_q == BEAT_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (pkt_we_i) begin
        words_left_q <= pkt_words_i;
        done_q       <= 1'b0;
      end
    end
  end

  assign burst_len_o = len_q;
  assign done_o      = done_q;
endmodule

// File: rtl/rx_addr_gen.sv
`timescale 1ns/1ps
module rx_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              step_i,
  input  logic [BEAT_W-1:0] len_i,
  input  logic              no_incr_i,
  input  logic              half_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, stride;

  assign stride = half_i ? (ADDR_W'(len_i) << 1) : (ADDR_W'(len_i) << 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 addr_q <= '0;
    else if (load_i)             addr_q <= {start_i[ADDR_W-1:2], 2'b00};
    else if (step_i && !no_incr_i) addr_q <= addr_q + stride;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/rx_burst_ctrl.sv
`timescale 1ns/1ps
module rx_burst_ctrl
  import rx_burst_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int DEPTH     = 32,
  parameter int MAX_BURST = 8,
  localparam int BEAT_W   = $clog2(MAX_BURST + 1),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int ENTRY_W  = DATA_W + 4,
  localparam int WORD_W   = SIZE_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  start_addr_i,
  input  logic               start_we_i,
  input  logic [SIZE_W-1:0]  pkt_bytes_i,
  input  logic               pkt_we_i,
  input  logic [BEAT_W-1:0]  max_beats_i,
  input  logic               no_incr_i,
  input  logic               half_mode_i,
  output logic               rd_req_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic [BEAT_W-1:0]  rd_beats_o,
  input  logic               rd_ack_i,
  input  logic               rd_valid_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  input  logic               pop_i,
  output logic [ENTRY_W-1:0] pop_data_o,
  output logic [CNT_W-1:0]   fifo_count_o,
  output logic               overflow_o,
  output logic               done_o
);
  logic [CNT_W-1:0]   free;
  logic               fire, push;
  logic [ENTRY_W-1:0] entry;

  assign free = CNT_W'(DEPTH) - fifo_count_o;
  assign entry = half_mode_i ?
                 {MASK_HALF, {(DATA_W/2){1'b0}}, rd_data_i[DATA_W/2-1:0]} :
                 {MASK_WORD, rd_data_i};

  rx_burst_fsm #(.MAX_BURST(MAX_BURST), .WORD_W(WORD_W), .CNT_W(CNT_W)) i_fsm (
    .clk_i, .rst_ni,
    .pkt_we_i,
    .pkt_words_i (pkt_bytes_i[SIZE_W-1:2]),
    .max_beats_i,
    .free_i      (free),
    .rd_ack_i, .rd_valid_i,
    .rd_req_o,
    .burst_len_o (rd_beats_o),
    .fire_o      (fire),
    .push_o      (push),
    .done_o
  );

  // start address is taken only while no request is pending
  rx_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_addr (
    .clk_i, .rst_ni,
    .load_i    (start_we_i && !rd_req_o),
    .start_i   (start_addr_i),
    .step_i    (fire),
    .len_i     (rd_beats_o),
    .no_incr_i,
    .half_i    (half_mode_i),
    .addr_o    (rd_addr_o)
  );

  rx_word_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) i_fifo (
    .clk_i, .rst_ni,
    .push_i     (push),
    .data_i     (entry),
    .pop_i,
    .data_o     (pop_data_o),
    .count_o    (fifo_count_o),
    .overflow_o
  );
endmodule

// File: rtl/rx_burst_ctrl_chk.sv
`timescale 1ns/1ps
module rx_burst_ctrl_chk #(
  parameter int ADDR_W    = 32,
  parameter int DEPTH     = 32,
  parameter int MAX_BURST = 8,
  parameter int BEAT_W    = 4,
  parameter int CNT_W     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic [BEAT_W-1:0] rd_beats_o,
  input logic [CNT_W-1:0]  fifo_count_o,
  input logic              overflow_o
);
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_beats_o));

  p_req_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> !rd_req_o);

  p_beats_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_beats_o != '0) && (32'(rd_beats_o) <= MAX_BURST));

  p_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> (32'(fifo_count_o) + 32'(rd_beats_o) <= DEPTH));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overflow_o);

  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fifo_count_o) <= DEPTH);
endmodule

bind rx_burst_ctrl rx_burst_ctrl_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .MAX_BURST(MAX_BURST), .BEAT_W(BEAT_W), .CNT_W(CNT_W)
) i_chk (
  .clk_i, .rst_ni, .rd_req_o, .rd_ack_i, .rd_addr_o, .rd_beats_o,
  .fifo_count_o, .overflow_o
);

// File: tb/test_rx_burst_ctrl.sv
`timescale 1ns/1ps
module test_rx_burst_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic        start_we_i = 1'b0;
  logic [15:0] pkt_bytes_i = '0;
  logic        pkt_we_i = 1'b0;
  logic [3:0]  max_beats_i = 4'd8;
  logic        no_incr_i = 1'b0;
  logic        half_mode_i = 1'b0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic [3:0]  rd_beats_o;
  logic        rd_ack_i = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        pop_i = 1'b0;
  logic [35:0] pop_data_o;
  logic [5:0]  fifo_count_o;
  logic        overflow_o;
  logic        done_o;

  always #5 clk_i = ~clk_i;

  rx_burst_ctrl i_rx_burst_ctrl (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] q_addr[$];
  int          q_len[$];
  logic [35:0] exp_q[$];
  logic [31:0] m_addr = '0;
  int m_cnt = 0, m_rem = 0;
  bit m_done = 0, drain_en = 0, live = 0;
  int req_seq = 0, beat_seq = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference occupancy / remaining / done
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_rem = 0; m_done = 0;
    end else begin
      automatic bit pop_ok = pop_i && (m_cnt > 0);
      if (rd_valid_i) begin
        m_cnt++;
        if (m_rem == 1) m_done = 1;
        m_rem--;
      end
      if (pop_ok) m_cnt--;
      if (pkt_we_i) begin
        m_rem = int'(pkt_bytes_i >> 2);
        m_done = 0;
      end
    end
  end

  always @(negedge clk_i) begin
    if (live) begin
      chk(fifo_count_o == 6'(m_cnt), "R1", "fifo count", fifo_count_o, m_cnt);
      chk(done_o == m_done, "R9", "done flag", done_o, m_done);
      chk(overflow_o == 1'b0, "R10", "overflow", overflow_o, 0);
    end
  end

  // drain side
  always @(negedge clk_i) begin
    pop_i <= 1'b0;
    if (live && drain_en && m_cnt > 0 && exp_q.size() > 0) begin
      chk(pop_data_o == exp_q[0], half_mode_i ? "R8" : "R1", "pop entry", pop_data_o, exp_q[0]);
      void'(exp_q.pop_front());
      pop_i <= 1'b1;
    end
  end

  // bus slave
  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_req_o) begin
        automatic int n = int'(rd_beats_o);
        if (q_len.size() == 0) begin
          chk(0, "R3", "unexpected request", rd_addr_o, 0);
        end else begin
          chk(rd_addr_o == q_addr[0], "R6", "request address", rd_addr_o, q_addr[0]);
          chk(n == q_len[0], "R5", "request beats", n, q_len[0]);
          void'(q_addr.pop_front());
          void'(q_len.pop_front());
        end
        chk(m_cnt + n <= 32, "R4", "room at request", m_cnt + n, 32);
        repeat (req_seq % 3) @(negedge clk_i);
        rd_ack_i = 1'b1;
        @(negedge clk_i);
        rd_ack_i = 1'b0;
        chk(rd_req_o == 1'b0, "R11", "request dropped after ack", rd_req_o, 0);
        for (int b = 0; b < n; b++) begin
          if (req_seq[0] && b == 1) @(negedge clk_i);
          rd_valid_i = 1'b1;
          rd_data_i = 32'hC0DE_0000 ^ {rd_addr_o[15:0], 16'(beat_seq)};
          exp_q.push_back(half_mode_i ? {4'h3, 16'h0, rd_data_i[15:0]} : {4'hF, rd_data_i});
          beat_seq++;
          @(negedge clk_i);
          rd_valid_i = 1'b0;
        end
        req_seq++;
      end
    end
  end

  task automatic set_start(logic [31:0] a);
    @(negedge clk_i);
    start_addr_i = a; start_we_i = 1'b1;
    m_addr = {a[31:2], 2'b00};
    @(negedge clk_i);
    start_we_i = 1'b0;
  endtask

  task automatic send_size(int bytes);
    automatic int w = bytes >> 2;
    automatic int eff = (max_beats_i == 0) ? 1 : ((max_beats_i > 8) ? 8 : int'(max_beats_i));
    while (w > 0) begin
      automatic int len = (w >= eff) ? eff : 1;
      q_addr.push_back(m_addr);
      q_len.push_back(len);
      w -= len;
      if (!no_incr_i) m_addr += 32'(len * (half_mode_i ? 2 : 4));
    end
    @(negedge clk_i);
    pkt_bytes_i = 16'(bytes); pkt_we_i = 1'b1;
    @(negedge clk_i);
    pkt_we_i = 1'b0;
  endtask

  task automatic finish_packet(string req);
    while (m_rem > 0 || q_len.size() > 0 || m_cnt > 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b1, req, "done after packet", done_o, 1);
    chk(q_len.size() == 0, req, "requests outstanding", q_len.size(), 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(fifo_count_o == 0, "R1", "reset count", fifo_count_o, 0);
    chk(rd_req_o == 0, "R11", "reset request", rd_req_o, 0);
    chk(done_o == 0, "R9", "reset done", done_o, 0);
    live = 1; drain_en = 1;

    // R5 full bursts
    set_start(32'h0000_1002);
    max_beats_i = 4'd8;
    send_size(64);
    finish_packet("R5");

    // R7 resume, R3 low bits ignored, R5 tail singles
    max_beats_i = 4'd4;
    send_size(43);
    finish_packet("R7");

    // R6 increment disabled
    set_start(32'h0000_2000);
    no_incr_i = 1'b1; max_beats_i = 4'd3;
    send_size(28);
    finish_packet("R6");
    no_incr_i = 1'b0;

    // R8 16-bit mode
    set_start(32'h0000_3000);
    half_mode_i = 1'b1; max_beats_i = 4'd2;
    send_size(20);
    finish_packet("R8");
    half_mode_i = 1'b0;

    // R2 clamping
    max_beats_i = 4'd0;
    send_size(8);
    finish_packet("R2");
    max_beats_i = 4'd15;
    send_size(36);
    finish_packet("R2");

    // R4 stall on full FIFO
    set_start(32'h0000_4000);
    max_beats_i = 4'd8; drain_en = 0;
    send_size(160);
    while (m_cnt < 32) @(negedge clk_i);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      chk(rd_req_o == 1'b0, "R4", "request while full", rd_req_o, 0);
    end
    drain_en = 1;
    finish_packet("R4");

    // R3 zero words
    send_size(3);
    repeat (20) @(negedge clk_i);
    chk(rd_req_o == 1'b0, "R3", "zero packet request", rd_req_o, 0);
    chk(done_o == 1'b0, "R3", "zero packet done", done_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule